// File: doc/BRIEF.md
# Break Address Match Interrupt Unit

This block watches the instruction-fetch side of a 24-bit CPU bus. When the CPU reads from the ROM region and the fetch address falls on one of 32 programmable break words, the block raises an interrupt request intended for the CPU's non-maskable input. Each break entry has its own enable flag. The compare covers address bits 19 down to 2, so a break point is a 4-byte word in a 1 MB space.

Software programs entries through a write-only window at the top 256 bytes of the address space (FFFF00H to FFFFFFH). The two high address bytes go into a holding register that all entries share. Writing the lowest byte copies the whole compare address into the chosen entry in one step, so an entry never compares against a half-written value. A read anywhere in the window returns the number of the matching entry and withdraws the request. When several entries hit in the same cycle, the lowest-numbered one is reported. The captured number and the request stay fixed until that read.

Top module: `brk_match_unit`

## Requirements
- R1: After reset, brk_irq is 0, every entry is disabled, and a status read returns 0.
- R2: A cycle with bus_rd=1 and rom_sel=1 whose bus_addr[19:2] equals the compare field of an enabled entry sets brk_irq=1 from the next clock edge. No request is pending before that cycle.
- R3: There is no match when rom_sel=0 or when the entry's enable flag is 0.
- R4: bus_addr[23:20] and bus_addr[1:0] have no effect on matching. Only bits 3:0 of the upper byte and bits 7:2 of the lower byte are kept.
- R5: Entry e takes window offsets 4e..4e+3, with e taken from bus_addr[6:2]. Offset +1 holds address bits 23..16 and offset +2 holds bits 15..8. Both go into one shared holding register and leave every entry unchanged. Writing offset +3 (bits 7..0) loads the holding register together with this byte into entry e.
- R6: A write to offset +0 sets the enable flag of entry e from wdata bit 7 (1 = enabled). The other bits of that byte and the compare address of the entry are not affected.
- R7: A read (bus_rd=1) at any address in FFFF00H..FFFFFFH is a status read. On the next clock edge, bus_rdata bits 4..0 hold the captured entry number in binary, bits 7..5 are 0, and brk_irq falls. The captured number is cleared to 0.
- R8: When several enabled entries match in the same cycle, the lowest-numbered entry is captured.
- R9: While a request is pending, new matches do not change the captured entry number.
- R10: A read outside the window does not clear a pending request, and bus_rdata is 0 on every cycle that does not follow a status read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 24 | CPU address |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| rom_sel | input | 1 | ROM chip-select qualifier for fetches |
| bus_rdata | output | 8 | Registered status read data |
| brk_irq | output | 1 | Break interrupt request, held until a status read |

## Verification
The assertions check the following on every cycle:
- the request sets whenever the encoder reports a hit with nothing pending;
- the request and the captured number hold while pending;
- a status read clears the request, and its upper data bits are 0;
- read data is 0 except after a status read;
- the encoder's result is the lowest active hit;
- writes to the holding bytes and the enable bytes do not touch the state they must leave alone.

Only the bench scenarios can show that the right value ends up in the right entry. These cover:
- commit through the shared holding register, including a commit into a different entry than the one named by the high-byte writes;
- the ignored address bits;
- aliased status reads at arbitrary window addresses;
- the number reported after overlapping matches.

// File: rtl/brk_pkg.sv
`timescale 1ns/1ps
package brk_pkg;
  // Byte lane inside one 4-byte entry slot of the programming window.
  typedef enum logic [1:0] {
    BY_EN  = 2'd0,
    BY_HI  = 2'd1,
    BY_MID = 2'd2,
    BY_LO  = 2'd3
  } byte_sel_e;

  localparam int DW = 8;
endpackage

// File: rtl/brk_prio_enc.sv
`timescale 1ns/1ps
module brk_prio_enc #(
  parameter int N  = 32,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic          any,
  output logic [IW-1:0] idx
);
  // Scan from the top so the lowest active request is the last to be written.
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        any = 1'b1;
        idx = IW'(i);
      end
    end
  end

  // The reported index is active, and no lower request is active.
  always_comb begin
    p_enc_lowest_r8: assert (!any || (req[idx] && ((req & ((N'(1) << idx) - N'(1))) == '0)));
  end
endmodule

// File: rtl/brk_entry_bank.sv
`timescale 1ns/1ps
module brk_entry_bank
  import brk_pkg::*;
#(
  parameter int N      = 32,
  parameter int CMP_HI = 19,
  parameter int CMP_LO = 2,
  parameter int IW     = (N > 1) ? $clog2(N) : 1,
  parameter int CW     = CMP_HI - CMP_LO + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [IW-1:0] ent_sel,
  input  byte_sel_e     byte_sel,
  input  logic [DW-1:0] wdata,
  input  logic          fetch_vld,
  input  logic [CW-1:0] fetch_cmp,
  output logic [N-1:0]  hit
);
  localparam int HI_BITS = CMP_HI - 2 * DW + 1;

  logic [N-1:0]          en_q;
  logic [N-1:0][CW-1:0]  cmp_q;
  logic [HI_BITS-1:0]    stage_hi_q;
  logic [DW-1:0]         stage_mid_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q        <= '0;
      cmp_q       <= '0;
      stage_hi_q  <= '0;
      stage_mid_q <= '0;
    end else if (wr_en) begin
      case (byte_sel)
        BY_EN:  en_q[ent_sel]  <= wdata[DW-1];
        BY_HI:  stage_hi_q     <= wdata[HI_BITS-1:0];
        BY_MID: stage_mid_q    <= wdata;
        BY_LO:  cmp_q[ent_sel] <= {stage_hi_q, stage_mid_q, wdata[DW-1:CMP_LO]};
        default: ;
      endcase
    end
  end

  // One comparator per entry, all evaluated in parallel on every fetch.
  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign hit[g] = fetch_vld & en_q[g] & (cmp_q[g] == fetch_cmp);
  end

  // R5: only a lower-byte write may change any compare address.
  p_stage_only_r5: assert property (@(posedge clk) disable iff (rst)
    (wr_en && byte_sel != BY_LO) |=> $stable(cmp_q));
  // R6: enable flags change only through enable-byte writes.
  p_en_isolated_r6: assert property (@(posedge clk) disable iff (rst)
    (!wr_en || byte_sel != BY_EN) |=> $stable(en_q));
endmodule

// File: rtl/brk_match_unit.sv
`timescale 1ns/1ps
module brk_match_unit
  import brk_pkg::*;
#(
  parameter int          N_ENT    = 32,
  parameter int          AW       = 24,
  parameter int          CMP_HI   = 19,
  parameter int          CMP_LO   = 2,
  parameter int          WIN_W    = 8,
  parameter logic [23:0] WIN_BASE = 24'hFFFF00
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_rd,
  input  logic          bus_wr,
  input  logic [DW-1:0] bus_wdata,
  input  logic          rom_sel,
  output logic [DW-1:0] bus_rdata,
  output logic          brk_irq
);
  localparam int IW = (N_ENT > 1) ? $clog2(N_ENT) : 1;
  localparam int CW = CMP_HI - CMP_LO + 1;

  logic          win_hit, status_rd, wr_win, fetch_vld;
  logic [N_ENT-1:0] hit;
  logic          any_hit;
  logic [IW-1:0] hit_idx;
  logic [IW-1:0] idx_q;
  logic          irq_q;

  // Window decode uses only the upper address bits, so all 256 bytes alias.
  assign win_hit   = (bus_addr[AW-1:WIN_W] == WIN_BASE[AW-1:WIN_W]);
  assign status_rd = bus_rd & win_hit;
  assign wr_win    = bus_wr & win_hit;
  assign fetch_vld = bus_rd & rom_sel;

  brk_entry_bank #(.N(N_ENT), .CMP_HI(CMP_HI), .CMP_LO(CMP_LO)) u_bank (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_win),
    .ent_sel   (bus_addr[IW+1:2]),
    .byte_sel  (byte_sel_e'(bus_addr[1:0])),
    .wdata     (bus_wdata),
    .fetch_vld (fetch_vld),
    .fetch_cmp (bus_addr[CMP_HI:CMP_LO]),
    .hit       (hit)
  );

  brk_prio_enc #(.N(N_ENT)) u_enc (
    .req (hit),
    .any (any_hit),
    .idx (hit_idx)
  );

  // A status read wins over a match in the same cycle; a pending capture is never replaced.
  always_ff @(posedge clk) begin
    if (rst) begin
      irq_q     <= 1'b0;
      idx_q     <= '0;
      bus_rdata <= '0;
    end else begin
      bus_rdata <= status_rd ? {{(DW-IW){1'b0}}, idx_q} : '0;
      if (status_rd) begin
        irq_q <= 1'b0;
        idx_q <= '0;
      end else if (!irq_q && any_hit) begin
        irq_q <= 1'b1;
        idx_q <= hit_idx;
      end
    end
  end

  assign brk_irq = irq_q;

  p_set_on_hit_r2: assert property (@(posedge clk) disable iff (rst)
    (!brk_irq && !status_rd && any_hit) |=> brk_irq);
  p_hold_pending_r9: assert property (@(posedge clk) disable iff (rst)
    (brk_irq && !status_rd) |=> (brk_irq && $stable(idx_q)));
  p_clear_on_read_r7: assert property (@(posedge clk) disable iff (rst)
    status_rd |=> (!brk_irq && bus_rdata[DW-1:IW] == '0));
  p_quiet_rdata_r10: assert property (@(posedge clk) disable iff (rst)
    !status_rd |=> (bus_rdata == '0));
endmodule

// File: tb/sim_brk_match_unit.sv
`timescale 1ns/1ps
module sim_brk_match_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [23:0] bus_addr = '0;
  logic        bus_rd = 1'b0, bus_wr = 1'b0, rom_sel = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic        brk_irq;

  always #2.5 clk = ~clk;

  brk_match_unit u0 (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .rom_sel(rom_sel), .bus_rdata(bus_rdata), .brk_irq(brk_irq)
  );

  // Reference state built from the requirements.
  logic        en_m  [32];
  logic [17:0] cmp_m [32];
  logic [7:0]  sh_m, sm_m;
  logic        pend_m;
  logic [4:0]  idx_m;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  localparam logic [23:0] WIN = 24'hFFFF00;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic int lowest_hit(logic [23:0] a);
    for (int i = 0; i < 32; i++)
      if (en_m[i] && cmp_m[i] == a[19:2]) return i;
    return -1;
  endfunction

  function automatic logic [23:0] slot(int e, int off);
    return WIN | 24'((e % 32) << 2) | 24'(off);
  endfunction

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic wr(logic [23:0] a, logic [7:0] d);
    int e;
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    cyc();
    bus_wr = 1'b0;
    if (a[23:8] == 16'hFFFF) begin
      e = int'(a[6:2]);
      case (a[1:0])
        2'd0: en_m[e] = d[7];
        2'd1: sh_m = d;
        2'd2: sm_m = d;
        default: cmp_m[e] = {sh_m[3:0], sm_m, d[7:2]};
      endcase
    end
  endtask

  task automatic prog(int e, logic [23:0] t, bit en);
    wr(slot(e, 1), t[23:16]);
    wr(slot(e, 2), t[15:8]);
    wr(slot(e, 3), t[7:0]);
    wr(slot(e, 0), en ? 8'h80 : 8'h00);
  endtask

  task automatic fetch(logic [23:0] a, bit rs, string tag);
    int h;
    bus_addr = a; bus_rd = 1'b1; rom_sel = rs;
    cyc();
    bus_rd = 1'b0; rom_sel = 1'b0;
    h = lowest_hit(a);
    if (rs && !pend_m && h >= 0) begin
      pend_m = 1'b1;
      idx_m  = 5'(h);
    end
    check(tag, brk_irq, pend_m);
  endtask

  task automatic status(logic [23:0] a, string tag);
    bus_addr = a; bus_rd = 1'b1;
    cyc();
    bus_rd = 1'b0;
    check(tag, bus_rdata, {3'b000, idx_m});
    pend_m = 1'b0;
    idx_m  = '0;
    check(tag, brk_irq, 1'b0);
  endtask

  task automatic plain_rd(logic [23:0] a, string tag);
    bus_addr = a; bus_rd = 1'b1;
    cyc();
    bus_rd = 1'b0;
    check(tag, bus_rdata, 8'h00);
    check(tag, brk_irq, pend_m);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 32; i++) begin en_m[i] = 0; cmp_m[i] = '0; end
    sh_m = '0; sm_m = '0; pend_m = 0; idx_m = '0;
    repeat (3) cyc();
    rst = 1'b0;
    cyc();
    // R1: idle state after reset
    check("R1", brk_irq, 1'b0);
    check("R1", bus_rdata, 8'h00);
    fetch(24'h000000, 1'b1, "R1");
    status(WIN, "R1");

    // Entry 5 at word 0xABCD4; extra bits in the written bytes are ignored
    prog(5, 24'hFABCD7, 1'b1);
    fetch(24'h0ABCD4, 1'b0, "R3");
    fetch(24'h0ABCD4, 1'b1, "R2");
    check("R2", brk_irq, 1'b1);
    plain_rd(24'h001000, "R10");
    status(24'hFFFF80, "R7");
    check("R7", {31'd0, pend_m}, 0);
    status(24'hFFFF3B, "R7");
    fetch(24'hFABCD7, 1'b1, "R4");
    check("R4", brk_irq, 1'b1);
    bus_addr = 24'hFFFFFF; bus_rd = 1'b1; cyc(); bus_rd = 1'b0;
    check("R7", bus_rdata, 8'h05);
    pend_m = 0; idx_m = '0;

    // R6: enable byte alone; low bits ignored
    wr(slot(5, 0), 8'h7F);
    fetch(24'h0ABCD4, 1'b1, "R6");
    check("R6", brk_irq, 1'b0);
    wr(slot(5, 0), 8'hFF);
    fetch(24'h0ABCD4, 1'b1, "R6");
    status(WIN, "R6");

    // R5: holding register shared; commit goes to entry named by the low write
    wr(slot(5, 1), 8'h03);
    wr(slot(5, 2), 8'h21);
    fetch(24'h0ABCD4, 1'b1, "R5");
    check("R5", brk_irq, 1'b1);
    status(WIN, "R5");
    wr(slot(9, 3), 8'h40);
    wr(slot(9, 0), 8'h80);
    fetch(24'h032140, 1'b1, "R5");
    bus_addr = WIN; bus_rd = 1'b1; cyc(); bus_rd = 1'b0;
    check("R5", bus_rdata, 8'h09);
    pend_m = 0; idx_m = '0;

    // R8: entries 2 and 9 share an address; entry 2 wins
    prog(2, 24'h032140, 1'b1);
    fetch(24'h032140, 1'b1, "R8");
    bus_addr = WIN; bus_rd = 1'b1; cyc(); bus_rd = 1'b0;
    check("R8", bus_rdata, 8'h02);
    pend_m = 0; idx_m = '0;

    // R9: first capture holds against later hits
    fetch(24'h0ABCD4, 1'b1, "R9");
    fetch(24'h032140, 1'b1, "R9");
    bus_addr = WIN; bus_rd = 1'b1; cyc(); bus_rd = 1'b0;
    check("R9", bus_rdata, 8'h05);
    pend_m = 0; idx_m = '0;

    // Entry 31 uses the top slot, whose lower byte shares the status address
    prog(31, 24'h0F0000, 1'b1);
    fetch(24'h0F0001, 1'b1, "R5");
    status(24'hFFFFFF, "R7");

    // Constrained random mix
    for (int it = 0; it < 600; it++) begin
      int op, e;
      logic [23:0] a;
      op = int'($urandom_range(0, 9));
      e  = int'($urandom_range(0, 31));
      if (op < 6) begin
        if (op < 4) a = {1'b0, 3'($urandom), cmp_m[e], 2'($urandom)};
        else        a = {1'b0, 23'($urandom)};
        fetch(a, ($urandom_range(0, 3) != 0), "R2");
      end else if (op == 6) begin
        status(WIN | 24'($urandom_range(0, 255)), "R7");
      end else if (op == 7) begin
        plain_rd({1'b0, 23'($urandom)}, "R10");
      end else if (op == 8) begin
        prog(e, 24'($urandom), ($urandom_range(0, 2) != 0));
      end else begin
        wr(slot(e, 0), 8'($urandom));
      end
    end
    status(WIN, "R7");

    done = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule